// File: doc/BRIEF.md
# Two-Channel DMA Channel Allocator with Pending Queue

This block hands out a small set of DMA channels (two by default) to requesters that identify themselves with an ID. Each request also carries a mask of the channels it can work with. When at least one acceptable channel is idle, the requester gets a channel at once. Channels are tried from the highest index downward. When no acceptable channel is idle, the request is parked in an age-ordered pending queue and the requester is told to wait.

A channel owner hands its channel back with a release. The channel is freed, and the pending queue is then searched from its oldest entry to its newest for a waiter that accepts that channel. That waiter need not sit at the head of the queue. It is pulled out, made the new owner, and announced on a start pulse that carries its ID and the channel. If no waiter accepts the channel, the channel stays idle. The owner ID and busy flag of every channel are visible at the ports.

Top module: `chan_alloc`

## Requirements
- R1: After synchronous reset, every channel is idle (`chan_busy` all zero), `rsp_valid` and `start_valid` are low and the pending queue is empty.
- R2: A request whose mask (bit i = channel i acceptable) includes an idle channel is answered one cycle later with `rsp_code` 1 (grant). `rsp_chan` gives the highest-index idle channel the mask allows. That channel becomes busy with `owner_ids[c*IDW +: IDW]` equal to the request ID.
- R3: A request whose acceptable channels are all busy is answered with `rsp_code` 2 (wait) and appended at the young end of the pending queue.
- R4: A request that would have to wait while the queue already holds DEPTH entries is answered with `rsp_code` 3 (reject), and the queue contents are left unchanged.
- R5: A request with an all-zero mask is answered with `rsp_code` 3 (reject) and is never queued.
- R6: Releasing a busy channel that no queued entry accepts leaves the channel idle from the next cycle, with no start pulse.
- R7: Releasing a busy channel that some queued entry accepts removes the oldest such entry, even when it is not at the head, and keeps the order of the rest. One cycle later, `start_valid` pulses with that entry's ID on `start_id` and the channel on `start_chan`. The channel stays busy with that ID as owner.
- R8: A release naming a channel that is already idle has no effect: no start pulse, busy flags unchanged, queue unchanged.
- R9: A release and a request in the same cycle are handled release first. The request may be granted the channel the release freed when no waiter claims it, and it may use a queue slot the release emptied. A grant and a start never name the same channel in one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per request |
| req_id | input | IDW | Requester ID |
| req_mask | input | NCH | Acceptable channels, bit i = channel i |
| rel_valid | input | 1 | Release strobe |
| rel_chan | input | CHW | Channel being handed back |
| rsp_valid | output | 1 | Response to the previous cycle's request |
| rsp_code | output | 2 | 1 grant, 2 wait, 3 reject |
| rsp_chan | output | CHW | Granted channel (zero unless grant) |
| start_valid | output | 1 | A queued requester has been given a channel |
| start_id | output | IDW | ID of the requester being started |
| start_chan | output | CHW | Channel it was given |
| chan_busy | output | NCH | Busy flag per channel |
| owner_ids | output | NCH*IDW | Owner ID per channel, channel c at bits c*IDW +: IDW |

## Verification
A release and a new request can land in the same cycle, and this is where the ordering rule matters. The bench drives both strobes together in two situations. In the first, the queue is empty and the freed channel is the only one the new request accepts, so the grant must name that channel. In the second, the queue is full and a waiter claims the freed channel, so the start pulse must name that waiter. The new request must then be parked in the slot that waiter left, not rejected. The order of later start pulses shows that the queue kept its age order across the removal.

// File: rtl/chan_alloc_pkg.sv
package chan_alloc_pkg;

    typedef enum logic [1:0] {
        RSP_NONE   = 2'd0,
        RSP_GRANT  = 2'd1,
        RSP_WAIT   = 2'd2,
        RSP_REJECT = 2'd3
    } rsp_e;

    typedef enum logic [1:0] {
        ACT_GRANT,
        ACT_PARK,
        ACT_REFUSE
    } req_act_e;

    function automatic int unsigned width_of(input int unsigned n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/chan_alloc_pick.sv
module chan_alloc_pick #(
    parameter int NCH = 2,
    parameter int CHW = 1
) (
    input  logic [NCH-1:0] allow,
    output logic           found,
    output logic [CHW-1:0] idx
);
    // Ascending scan: the last match, i.e. the highest index, wins.
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int c = 0; c < NCH; c++) begin
            if (allow[c]) begin
                found = 1'b1;
                idx   = CHW'(c);
            end
        end
    end
endmodule

// File: rtl/chan_alloc_queue.sv
module chan_alloc_queue #(
    parameter int NCH   = 2,
    parameter int CHW   = 1,
    parameter int IDW   = 4,
    parameter int DEPTH = 8,
    parameter int IXW   = 3,
    parameter int CNTW  = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [CHW-1:0]  srch_chan,
    input  logic            rm_en,
    input  logic            push_en,
    input  logic [IDW-1:0]  push_id,
    input  logic [NCH-1:0]  push_mask,
    output logic [CNTW-1:0] count,
    output logic [CNTW-1:0] cnt_mid,
    output logic            hit,
    output logic [IXW-1:0]  hit_idx,
    output logic [IDW-1:0]  hit_id
);
    logic [IDW-1:0] slot_id   [DEPTH];
    logic [NCH-1:0] slot_mask [DEPTH];

    assign cnt_mid = count - CNTW'(rm_en);

    // Oldest live entry accepting srch_chan: descending scan, lowest index wins.
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int k = DEPTH - 1; k >= 0; k--) begin
            if (CNTW'(k) < count && slot_mask[k][srch_chan]) begin
                hit     = 1'b1;
                hit_idx = IXW'(k);
            end
        end
    end

    assign hit_id = slot_id[hit_idx];

    for (genvar g = 0; g < DEPTH; g++) begin : g_slot
        logic [IDW-1:0] id_r;
        logic [NCH-1:0] mask_r;
        logic [IDW-1:0] up_id;
        logic [NCH-1:0] up_mask;

        if (g < DEPTH - 1) begin : g_up
            assign up_id   = slot_id[g+1];
            assign up_mask = slot_mask[g+1];
        end else begin : g_top
            assign up_id   = '0;
            assign up_mask = '0;
        end

        always_ff @(posedge clk) begin
            if (rst) begin
                id_r   <= '0;
                mask_r <= '0;
            end else if (push_en && CNTW'(g) == cnt_mid) begin
                id_r   <= push_id;
                mask_r <= push_mask;
            end else if (rm_en && IXW'(g) >= hit_idx) begin
                id_r   <= up_id;
                mask_r <= up_mask;
            end
        end

        assign slot_id[g]   = id_r;
        assign slot_mask[g] = mask_r;
    end

    always_ff @(posedge clk) begin
        if (rst) count <= '0;
        else     count <= cnt_mid + CNTW'(push_en);
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (rst)
        push_en |-> (cnt_mid < CNTW'(DEPTH)));

    assert_live_removal_R7: assert property (@(posedge clk) disable iff (rst)
        rm_en |-> (hit && CNTW'(hit_idx) < count));

    assert_count_bound_R3: assert property (@(posedge clk) disable iff (rst)
        count <= CNTW'(DEPTH));
endmodule

// File: rtl/chan_alloc.sv
module chan_alloc
    import chan_alloc_pkg::*;
#(
    parameter int NCH   = 2,
    parameter int IDW   = 4,
    parameter int DEPTH = 8,
    localparam int CHW  = width_of(NCH),
    localparam int IXW  = width_of(DEPTH),
    localparam int CNTW = $clog2(DEPTH + 1)
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               req_valid,
    input  logic [IDW-1:0]     req_id,
    input  logic [NCH-1:0]     req_mask,
    input  logic               rel_valid,
    input  logic [CHW-1:0]     rel_chan,
    output logic               rsp_valid,
    output logic [1:0]         rsp_code,
    output logic [CHW-1:0]     rsp_chan,
    output logic               start_valid,
    output logic [IDW-1:0]     start_id,
    output logic [CHW-1:0]     start_chan,
    output logic [NCH-1:0]     chan_busy,
    output logic [NCH*IDW-1:0] owner_ids
);
    logic [NCH-1:0] busy_q;
    logic [IDW-1:0] owner_q [NCH];

    logic            rel_ok;
    logic            rm_en;
    logic            q_hit;
    logic [IXW-1:0]  q_hit_idx;
    logic [IDW-1:0]  q_hit_id;
    logic [CNTW-1:0] q_count;
    logic [CNTW-1:0] q_cnt_mid;
    logic [NCH-1:0]  busy_mid;
    logic            pick_found;
    logic [CHW-1:0]  pick_idx;
    req_act_e        act;
    logic            push_en;

    // Release stage first.
    assign rel_ok = rel_valid && busy_q[rel_chan];
    assign rm_en  = rel_ok && q_hit;

    always_comb begin
        busy_mid = busy_q;
        if (rel_ok && !q_hit) busy_mid[rel_chan] = 1'b0;
    end

    chan_alloc_queue #(
        .NCH(NCH), .CHW(CHW), .IDW(IDW), .DEPTH(DEPTH), .IXW(IXW), .CNTW(CNTW)
    ) u_queue (
        .clk       (clk),
        .rst       (rst),
        .srch_chan (rel_chan),
        .rm_en     (rm_en),
        .push_en   (push_en),
        .push_id   (req_id),
        .push_mask (req_mask),
        .count     (q_count),
        .cnt_mid   (q_cnt_mid),
        .hit       (q_hit),
        .hit_idx   (q_hit_idx),
        .hit_id    (q_hit_id)
    );

    // Request stage sees the post-release state.
    chan_alloc_pick #(.NCH(NCH), .CHW(CHW)) u_pick (
        .allow (req_mask & ~busy_mid),
        .found (pick_found),
        .idx   (pick_idx)
    );

    always_comb begin
        if (pick_found)                                       act = ACT_GRANT;
        else if (req_mask == '0 || q_cnt_mid == CNTW'(DEPTH)) act = ACT_REFUSE;
        else                                                  act = ACT_PARK;
    end

    assign push_en = req_valid && (act == ACT_PARK);

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q <= '0;
            for (int c = 0; c < NCH; c++) owner_q[c] <= '0;
        end else begin
            busy_q <= busy_mid;
            if (rm_en) owner_q[rel_chan] <= q_hit_id;
            if (req_valid && act == ACT_GRANT) begin
                busy_q[pick_idx]  <= 1'b1;
                owner_q[pick_idx] <= req_id;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid   <= 1'b0;
            rsp_code    <= RSP_NONE;
            rsp_chan    <= '0;
            start_valid <= 1'b0;
            start_id    <= '0;
            start_chan  <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_chan  <= '0;
            if (!req_valid) rsp_code <= RSP_NONE;
            else begin
                case (act)
                    ACT_GRANT: begin
                        rsp_code <= RSP_GRANT;
                        rsp_chan <= pick_idx;
                    end
                    ACT_PARK: rsp_code <= RSP_WAIT;
                    default:  rsp_code <= RSP_REJECT;
                endcase
            end
            start_valid <= rm_en;
            start_id    <= rm_en ? q_hit_id : '0;
            start_chan  <= rm_en ? rel_chan : '0;
        end
    end

    assign chan_busy = busy_q;
    for (genvar c = 0; c < NCH; c++) begin : g_own
        assign owner_ids[c*IDW +: IDW] = owner_q[c];
    end

    assert_grant_owned_R2: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_code == RSP_GRANT) |-> (busy_q[rsp_chan] && owner_q[rsp_chan] == $past(req_id)));

    assert_start_owned_R7: assert property (@(posedge clk) disable iff (rst)
        start_valid |-> (busy_q[start_chan] && owner_q[start_chan] == start_id));

    assert_distinct_chan_R9: assert property (@(posedge clk) disable iff (rst)
        (start_valid && rsp_valid && rsp_code == RSP_GRANT) |-> (start_chan != rsp_chan));

    assert_idle_release_R8: assert property (@(posedge clk) disable iff (rst)
        (rel_valid && !busy_q[rel_chan] && !req_valid) |=> (!start_valid && busy_q == $past(busy_q)));

    assert_zero_mask_R5: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_mask == '0) |=> (rsp_code == RSP_REJECT));
endmodule

// File: tb/chan_alloc_bench.sv
module chan_alloc_bench;
    localparam int NCH = 2, IDW = 4, DEPTH = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [IDW-1:0] req_id = '0;
    logic [NCH-1:0] req_mask = '0;
    logic rel_valid = 1'b0;
    logic rel_chan = 1'b0;
    logic rsp_valid;
    logic [1:0] rsp_code;
    logic rsp_chan;
    logic start_valid;
    logic [IDW-1:0] start_id;
    logic start_chan;
    logic [NCH-1:0] chan_busy;
    logic [NCH*IDW-1:0] owner_ids;

    always #5 clk = ~clk;

    chan_alloc #(.NCH(NCH), .IDW(IDW), .DEPTH(DEPTH)) u_chan_alloc (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_id(req_id), .req_mask(req_mask),
        .rel_valid(rel_valid), .rel_chan(rel_chan),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_chan(rsp_chan),
        .start_valid(start_valid), .start_id(start_id), .start_chan(start_chan),
        .chan_busy(chan_busy), .owner_ids(owner_ids)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    int    exp_rsp_code[$];
    int    exp_rsp_chan[$];
    string exp_rsp_tag[$];
    int    exp_st_id[$];
    int    exp_st_chan[$];
    string exp_st_tag[$];

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Monitor: pops scoreboard entries as results appear.
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (rsp_valid) begin
                if (exp_rsp_code.size() == 0) check(1'b0, "R2 unexpected response", int'(rsp_code), 0);
                else begin
                    automatic int ec = exp_rsp_code.pop_front();
                    automatic int eh = exp_rsp_chan.pop_front();
                    automatic string t = exp_rsp_tag.pop_front();
                    check(int'(rsp_code) == ec, {t, " code"}, int'(rsp_code), ec);
                    if (ec == 1) check(int'(rsp_chan) == eh, {t, " channel"}, int'(rsp_chan), eh);
                end
            end
            if (start_valid) begin
                if (exp_st_id.size() == 0) check(1'b0, "R6 unexpected start", int'(start_id), -1);
                else begin
                    automatic int ei = exp_st_id.pop_front();
                    automatic int eh = exp_st_chan.pop_front();
                    automatic string t = exp_st_tag.pop_front();
                    check(int'(start_id) == ei, {t, " start id"}, int'(start_id), ei);
                    check(int'(start_chan) == eh, {t, " start channel"}, int'(start_chan), eh);
                end
            end
        end
    end

    task automatic op(input bit do_req, input int id, input int mask, input int ecode, input int ech,
                      input bit do_rel, input int rch, input bit est, input int eid, input string tag);
        @(negedge clk);
        req_valid = do_req;
        req_id    = IDW'(id);
        req_mask  = NCH'(mask);
        rel_valid = do_rel;
        rel_chan  = rch[0];
        if (do_req) begin
            exp_rsp_code.push_back(ecode);
            exp_rsp_chan.push_back(ech);
            exp_rsp_tag.push_back(tag);
        end
        if (est) begin
            exp_st_id.push_back(eid);
            exp_st_chan.push_back(rch);
            exp_st_tag.push_back(tag);
        end
        @(negedge clk);
        req_valid = 1'b0;
        rel_valid = 1'b0;
        if (do_rel && !est) check(start_valid == 1'b0, {tag, " no start"}, int'(start_valid), 0);
    endtask

    function automatic int owner(input int c);
        return int'(owner_ids[c*IDW +: IDW]);
    endfunction

    task automatic summary;
        check(exp_rsp_code.size() == 0, "R2 responses outstanding", exp_rsp_code.size(), 0);
        check(exp_st_id.size() == 0, "R7 starts outstanding", exp_st_id.size(), 0);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check(chan_busy == '0, "R1 busy after reset", int'(chan_busy), 0);
        check(rsp_valid == 1'b0, "R1 rsp_valid after reset", int'(rsp_valid), 0);
        check(start_valid == 1'b0, "R1 start_valid after reset", int'(start_valid), 0);

        op(1, 1, 3, 1, 1, 0, 0, 0, 0, "R2 highest free");
        check(owner(1) == 1, "R2 owner ch1", owner(1), 1);
        op(1, 2, 3, 1, 0, 0, 0, 0, 0, "R2 next free");
        check(chan_busy == 2'b11, "R2 both busy", int'(chan_busy), 3);
        op(1, 3, 1, 2, 0, 0, 0, 0, 0, "R3 wait a");
        op(1, 4, 2, 2, 0, 0, 0, 0, 0, "R3 wait b");
        op(1, 5, 1, 2, 0, 0, 0, 0, 0, "R3 wait c");
        op(1, 6, 0, 3, 0, 0, 0, 0, 0, "R5 zero mask");
        op(0, 0, 0, 0, 0, 1, 1, 1, 4, "R7 non-head waiter");
        check(owner(1) == 4, "R7 owner ch1", owner(1), 4);
        op(0, 0, 0, 0, 0, 1, 0, 1, 3, "R7 head waiter");
        check(owner(0) == 3, "R7 owner ch0", owner(0), 3);
        op(0, 0, 0, 0, 0, 1, 0, 1, 5, "R7 last waiter (R5 entry never queued)");
        op(0, 0, 0, 0, 0, 1, 0, 0, 0, "R6 release no waiter");
        check(chan_busy == 2'b10, "R6 ch0 idle", int'(chan_busy), 2);
        op(0, 0, 0, 0, 0, 1, 0, 0, 0, "R8 idle release");
        check(chan_busy == 2'b10, "R8 busy unchanged", int'(chan_busy), 2);
        // R9 same cycle, freed channel granted
        op(1, 7, 2, 1, 1, 1, 1, 0, 0, "R9 release then grant");
        check(owner(1) == 7, "R9 owner ch1", owner(1), 7);
        op(1, 8, 3, 1, 0, 0, 0, 0, 0, "R2 low channel");
        op(1, 9, 2, 2, 0, 0, 0, 0, 0, "R3 fill 1");
        for (int k = 10; k < 17; k++) op(1, k % 16, 1, 2, 0, 0, 0, 0, 0, "R3 fill");
        op(1, 2, 3, 3, 0, 0, 0, 0, 0, "R4 full reject");
        op(0, 0, 0, 0, 0, 1, 1, 1, 9, "R4 queue intact");
        op(1, 3, 2, 2, 0, 0, 0, 0, 0, "R3 refill");
        // R9 same cycle on a full queue: waiter takes ch0, request uses freed slot
        op(1, 4, 3, 2, 0, 1, 0, 1, 10, "R9 full queue slot reuse");
        op(0, 0, 0, 0, 0, 1, 1, 1, 3, "R7 order after removal");
        op(0, 0, 0, 0, 0, 1, 1, 1, 4, "R9 parked request kept");
        repeat (3) @(negedge clk);
        finished = 1'b1;
        summary();
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            check(1'b0, "watchdog expired", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end
endmodule